// File: doc/BRIEF.md
# Dual-Width Transmit Serializer

This block turns parallel transmit words into a serial bit stream. A word is captured whenever the word-clock strobe is high at a clock edge. The block then shifts it out one bit per bit-clock enable. A width-select input picks between narrow words and wide words. By default these are 10-bit and 20-bit words, so the bit rate is ten or twenty times the word rate. The clocks are not generated here. Both the bit-clock enable and the word strobe come from outside, so the block runs on one fabric clock.

The captured word waits in a holding register. It moves into the shift register on the first bit enable that falls on a word boundary. A word captured while the previous one is still shifting therefore follows it with no gap and no repeated bit. Two output-enable inputs gate the serial output. Whenever either is low, the line sits at a fixed idle level while shifting carries on internally.

Top module: `sertx_dualwidth`

## Requirements
- R1: While `rst` is high and on the first edge after it, `ser_out` is at the idle level (default 0) and no word is pending.
- R2: A word on `par_in` is captured at each edge where `word_stb` is high. The value of `par_in` at other edges has no effect.
- R3: With `width_sel` = 0 (narrow) at capture, the word is emitted as bus bits 10, 11, …, 19 in that order. Bits 0 to 9 of the bus have no effect on the line.
- R4: With `width_sel` = 1 (wide) at capture, the word is emitted as bus bits 0, 1, …, 19 in that order.
- R5: A word captured before the previous word's last bit is emitted starting on the very next bit enable after that last bit.
- R6: At a word boundary with no captured word pending, each bit enable emits the idle level. The next captured word starts on the first bit enable after its capture.
- R7: `ser_out` carries data only while `oe_a` and `oe_b` are both high at the bit enable. Otherwise it is the idle level, and the word keeps advancing one bit per enable.
- R8: The width is sampled only at capture. Changing `width_sel` between strobes does not alter a word that is already captured or shifting.
- R9: `ser_out` is registered and changes only on an edge where `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable, one pulse per serial bit |
| word_stb | input | 1 | Word-clock strobe, captures `par_in` |
| width_sel | input | 1 | 0 = narrow word, 1 = wide word |
| par_in | input | WIDE_W | Parallel transmit word |
| oe_a | input | 1 | Output enable A |
| oe_b | input | 1 | Output enable B |
| ser_out | output | 1 | Serial data line |

## Verification
The bench changes `width_sel` and scrambles `par_in` right after each strobe. A design that sampled the width late, or read the bus at load time, would emit the junk and be caught. A second word is captured while the first is mid-shift. A loader that waits one enable, or refetches, would put a gap or a repeated bit at the join. The bench also drops each output enable for part of a word. If shifting paused with the line, every later bit would come out offset. Runs of enables with no word pending must give the idle level, and the next word must then start cleanly.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  // Default geometry: narrow word is the upper half of the wide bus.
  localparam int unsigned DEF_NARROW_W = 10;
  localparam int unsigned DEF_WIDE_W   = 20;

  typedef enum logic {
    WIDTH_NARROW = 1'b0,
    WIDTH_WIDE   = 1'b1
  } width_e;
endpackage

// File: rtl/sertx_capture.sv
module sertx_capture #(
  parameter int unsigned WIDE_W = sertx_pkg::DEF_WIDE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_stb,
  input  logic              width_sel,
  input  logic [WIDE_W-1:0] par_in,
  input  logic              take,
  output logic              pend,
  output logic              pend_wide,
  output logic [WIDE_W-1:0] pend_word
);
  // Holding register: a strobe always wins over the shifter's take,
  // so a word captured on the loading edge is kept for the next boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_wide <= 1'b0;
      pend_word <= '0;
    end else if (word_stb) begin
      pend      <= 1'b1;
      pend_wide <= (width_sel == sertx_pkg::WIDTH_WIDE);
      pend_word <= par_in;
    end else if (take) begin
      pend      <= 1'b0;
    end
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int unsigned NARROW_W = sertx_pkg::DEF_NARROW_W,
  parameter int unsigned WIDE_W   = sertx_pkg::DEF_WIDE_W,
  localparam int unsigned CNT_W   = $clog2(WIDE_W + 1),
  localparam int unsigned LO      = WIDE_W - NARROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              pend,
  input  logic              pend_wide,
  input  logic [WIDE_W-1:0] pend_word,
  output logic              take,
  output logic              out_vld,
  output logic              out_bit,
  output logic [CNT_W-1:0]  bits_left
);
  logic [WIDE_W-1:0] sreg;
  logic [WIDE_W-1:0] field;
  logic              at_bound;

  // Narrow words live in the upper part of the bus; both widths go out
  // lowest index first, so the field is right-aligned and shifted right.
  always_comb begin
    if (pend_wide) field = pend_word;
    else           field = {{LO{1'b0}}, pend_word[WIDE_W-1:LO]};
  end

  assign at_bound = (bits_left == '0);
  assign take     = bit_en && at_bound && pend;

  always_comb begin
    out_vld = 1'b0;
    out_bit = 1'b0;
    if (take) begin
      out_vld = 1'b1;
      out_bit = field[0];
    end else if (bit_en && !at_bound) begin
      out_vld = 1'b1;
      out_bit = sreg[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg      <= '0;
      bits_left <= '0;
    end else if (take) begin
      sreg      <= field >> 1;
      bits_left <= pend_wide ? CNT_W'(WIDE_W - 1) : CNT_W'(NARROW_W - 1);
    end else if (bit_en && !at_bound) begin
      sreg      <= sreg >> 1;
      bits_left <= bits_left - CNT_W'(1);
    end
  end
endmodule

// File: rtl/sertx_outstage.sv
module sertx_outstage #(
  parameter logic IDLE_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic out_vld,
  input  logic out_bit,
  input  logic oe_a,
  input  logic oe_b,
  output logic ser_out
);
  always_ff @(posedge clk) begin
    if (rst)
      ser_out <= IDLE_LEVEL;
    else if (bit_en)
      ser_out <= (out_vld && oe_a && oe_b) ? out_bit : IDLE_LEVEL;
  end
endmodule

// File: rtl/sertx_dualwidth.sv
module sertx_dualwidth #(
  parameter int unsigned NARROW_W   = sertx_pkg::DEF_NARROW_W,
  parameter int unsigned WIDE_W     = sertx_pkg::DEF_WIDE_W,
  parameter logic        IDLE_LEVEL = 1'b0,
  localparam int unsigned CNT_W     = $clog2(WIDE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              word_stb,
  input  logic              width_sel,
  input  logic [WIDE_W-1:0] par_in,
  input  logic              oe_a,
  input  logic              oe_b,
  output logic              ser_out
);
  logic              take;
  logic              pend;
  logic              pend_wide;
  logic [WIDE_W-1:0] pend_word;
  logic              out_vld;
  logic              out_bit;
  logic [CNT_W-1:0]  bits_left;

  sertx_capture #(.WIDE_W(WIDE_W)) i_capture (
    .clk(clk), .rst(rst), .word_stb(word_stb), .width_sel(width_sel),
    .par_in(par_in), .take(take), .pend(pend), .pend_wide(pend_wide),
    .pend_word(pend_word)
  );

  sertx_shifter #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) i_shifter (
    .clk(clk), .rst(rst), .bit_en(bit_en), .pend(pend),
    .pend_wide(pend_wide), .pend_word(pend_word), .take(take),
    .out_vld(out_vld), .out_bit(out_bit), .bits_left(bits_left)
  );

  sertx_outstage #(.IDLE_LEVEL(IDLE_LEVEL)) i_outstage (
    .clk(clk), .rst(rst), .bit_en(bit_en), .out_vld(out_vld),
    .out_bit(out_bit), .oe_a(oe_a), .oe_b(oe_b), .ser_out(ser_out)
  );
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker #(
  parameter int unsigned NARROW_W   = 10,
  parameter int unsigned WIDE_W     = 20,
  parameter logic        IDLE_LEVEL = 1'b0,
  localparam int unsigned CNT_W     = $clog2(WIDE_W + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_en,
  input logic             word_stb,
  input logic             oe_a,
  input logic             oe_b,
  input logic             ser_out,
  input logic             take,
  input logic             pend,
  input logic             pend_wide,
  input logic [CNT_W-1:0] bits_left
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (ser_out == IDLE_LEVEL && !pend)); // R1
  AST_STB_PENDS: assert property (@(posedge clk) disable iff (rst) word_stb |=> pend); // R2
  AST_NARROW_LEN: assert property (@(posedge clk) disable iff (rst) (take && !pend_wide) |=> bits_left == CNT_W'(NARROW_W - 1)); // R3
  AST_WIDE_LEN: assert property (@(posedge clk) disable iff (rst) (take && pend_wide) |=> bits_left == CNT_W'(WIDE_W - 1)); // R4
  AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (rst) bits_left < CNT_W'(WIDE_W)); // R4
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst) (take && !word_stb) |=> !pend); // R5
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst) (bit_en && !(oe_a && oe_b)) |=> ser_out == IDLE_LEVEL); // R7
  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (rst) !bit_en |=> $stable(ser_out)); // R9
endmodule

bind sertx_dualwidth sertx_checker #(
  .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .IDLE_LEVEL(IDLE_LEVEL)
) i_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .word_stb(word_stb),
  .oe_a(oe_a), .oe_b(oe_b), .ser_out(ser_out), .take(take),
  .pend(pend), .pend_wide(pend_wide), .bits_left(bits_left)
);

// File: tb/test_sertx_dualwidth.sv
`timescale 1ns/1ps
module test_sertx_dualwidth;
  localparam int NW = 10;
  localparam int WW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bit_en = 1'b0;
  logic          word_stb = 1'b0;
  logic          width_sel = 1'b0;
  logic [WW-1:0] par_in = '0;
  logic          oe_a = 1'b1;
  logic          oe_b = 1'b1;
  logic          ser_out;

  int n_checks = 0;
  int n_fail   = 0;

  logic  exp_q[$];
  string req_q[$];
  logic  en_seen = 1'b0;
  logic  last_out = 1'b0;
  bit    started = 1'b0;

  always #10 clk = ~clk;

  sertx_dualwidth i_sertx_dualwidth (
    .clk(clk), .rst(rst), .bit_en(bit_en), .word_stb(word_stb),
    .width_sel(width_sel), .par_in(par_in), .oe_a(oe_a), .oe_b(oe_b),
    .ser_out(ser_out)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ser_out=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected bit per bit enable; between enables the line must hold.
  always @(posedge clk) en_seen <= bit_en & ~rst;

  always @(negedge clk) begin
    if (!rst && started) begin
      if (en_seen) begin
        if (exp_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R2: ser_out=%b expected=<none queued>", ser_out);
        end else begin
          check(ser_out, exp_q.pop_front(), req_q.pop_front());
        end
      end else begin
        check(ser_out, last_out, "R9 hold");
      end
      last_out = ser_out;
    end
  end

  function automatic logic exp_bit(input logic [WW-1:0] d, input logic wide,
                                   input int idx, input logic on);
    if (!on) return 1'b0;
    return wide ? d[idx] : d[NW + idx];
  endfunction

  task automatic cyc(input logic en, input logic stb, input logic [WW-1:0] d,
                     input logic ws, input logic a, input logic b,
                     input logic e, input string req);
    @(negedge clk);
    bit_en = en; word_stb = stb; par_in = d; width_sel = ws; oe_a = a; oe_b = b;
    if (en) begin exp_q.push_back(e); req_q.push_back(req); end
  endtask

  // Strobe one word, then shift it out with scrambled bus and flipped width (R2, R8).
  task automatic send_one(input logic [WW-1:0] d, input logic w, input int gap,
                          input int a_lo, input int a_hi, input int b_lo, input int b_hi,
                          input string req);
    int n = w ? WW : NW;
    cyc(1'b0, 1'b1, d, w, 1'b1, 1'b1, 1'b0, req);
    for (int j = 0; j < n; j++) begin
      logic a = !(j >= a_lo && j <= a_hi);
      logic b = !(j >= b_lo && j <= b_hi);
      cyc(1'b1, 1'b0, ~d, ~w, a, b, exp_bit(d, w, j, a & b), req);
      for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0, ~d, ~w, a, b, 1'b0, req);
    end
  endtask

  // Second word captured while the first is shifting (R5, R8).
  task automatic send_pair(input logic [WW-1:0] da, input logic wa,
                           input logic [WW-1:0] db, input logic wb);
    int na = wa ? WW : NW;
    int nb = wb ? WW : NW;
    cyc(1'b0, 1'b1, da, wa, 1'b1, 1'b1, 1'b0, "R5");
    for (int j = 0; j < na; j++) begin
      if (j == 2) cyc(1'b1, 1'b1, db, wb, 1'b1, 1'b1, exp_bit(da, wa, j, 1'b1), "R8 first word");
      else        cyc(1'b1, 1'b0, ~db, ~wb, 1'b1, 1'b1, exp_bit(da, wa, j, 1'b1), "R8 first word");
      cyc(1'b0, 1'b0, ~db, ~wb, 1'b1, 1'b1, 1'b0, "R5");
    end
    for (int j = 0; j < nb; j++) begin
      cyc(1'b1, 1'b0, ~db, ~wb, 1'b1, 1'b1, exp_bit(db, wb, j, 1'b1), "R5 second word");
      cyc(1'b0, 1'b0, ~db, ~wb, 1'b1, 1'b1, 1'b0, "R5");
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(ser_out, 1'b0, "R1 reset idle");
    rst = 1'b0;
    @(negedge clk);
    check(ser_out, 1'b0, "R1 after reset");
    last_out = ser_out;
    started = 1'b1;
    // No word pending: enables emit idle (R1, R6).
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, 20'hFFFFF, 1'b0, 1'b1, 1'b1, 1'b0, "R6 idle");
    send_one(20'hA5_3_C6, 1'b0, 1, -1, -1, -1, -1, "R3 narrow");
    send_one(20'h6B_2_D1, 1'b0, 1, -1, -1, -1, -1, "R3 narrow low half");
    send_one(20'h6B_2_2E, 1'b0, 0, -1, -1, -1, -1, "R3 narrow low half b2b");
    send_one(20'h9_1E_47, 1'b1, 1, -1, -1, -1, -1, "R4 wide");
    send_one(20'h3_C4_B5, 1'b1, 0, -1, -1, -1, -1, "R4 wide dense");
    send_pair(20'hC3_5_A9, 1'b0, 20'h5A_F_0E, 1'b1);
    send_pair(20'h7_E1_93, 1'b1, 20'hD2_6_5B, 1'b0);
    send_one(20'hFFFFF, 1'b1, 1, 5, 9, 12, 13, "R7 enables");
    send_one(20'hFFFFF, 1'b0, 0, -1, -1, 0, 3, "R7 enable b");
    // Underrun then restart (R6).
    for (int k = 0; k < 4; k++) cyc(1'b1, 1'b0, 20'h0, 1'b1, 1'b1, 1'b1, 1'b0, "R6 underrun");
    cyc(1'b0, 1'b0, 20'h0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
    send_one(20'h8E_1_77, 1'b0, 1, -1, -1, -1, -1, "R6 restart");
    send_one(20'h1_7B_C2, 1'b1, 2, -1, -1, -1, -1, "R4 wide sparse");
    cyc(1'b0, 1'b0, 20'h0, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
    repeat (4) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: %0d expected bits never emitted, expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule